// File: doc/BRIEF.md
# Two-Stage Cascaded Interrupt Controller with Per-Line Trigger Select

This block collects sixteen interrupt lines and presents one request to the host. It is built from two eight-line priority units. The upper unit covers lines 8 to 15, and its combined request drives line 2 of the lower unit. Each line has its own mask bit and its own select between edge and level detection. Five lines are fixed to edge detection and cannot be changed.

The host reads and writes byte-wide registers through a simple register bus. It acknowledges the request with a one-cycle pulse, and the block then reports the winning line as a vector. That line stays in service until the host writes end-of-interrupt commands.

For an upper-unit line the host sends the end-of-interrupt to the upper unit first, then to the lower unit. For a lower-unit line it sends one command, to the lower unit only. The line number is recovered from the vector as (vector − 0x800) >> 4.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After a synchronous reset:
  - every mask bit of both units is 1;
  - every trigger-select bit is 0;
  - no line is requesting or in service;
  - `host_irq` is 0 and `vec_out` is 0x800.
- R2: Line n lives at bit n%8 of unit n/8, where `reg_sel` 0 selects the lower unit and 1 selects the upper unit. Writing offset 1 of a unit sets its mask register, and reading offset 1 returns it. A 1 bit blocks the line and a 0 bit lets it request.
- R3: The trigger-select register is `reg_sel` 2. Offset 0 covers lines 0–7 and offset 1 covers lines 8–15. A 1 bit selects level detection and a 0 bit selects edge detection. The bits of lines 0, 1, 2, 8 and 13 always read 0, even after a write of 1.
- R4: An edge-detected line latches a request on a low-to-high change of its input. The request stays latched after the input falls, until the line is acknowledged.
- R5: A level-detected line requests while its input is high. Its request disappears if the input falls before acknowledge, and an acknowledge with no request pending changes neither `vec_out` nor the in-service state.
- R6: The upper unit's request drives line 2 of the lower unit, and the `irq_in[2]` pin has no effect. Setting lower-unit mask bit 2 keeps every request from lines 8–15 away from `host_irq`.
- R7: Within each unit, the lowest bit has the highest priority. An upper-unit line competes at the priority of lower-unit line 2, so it beats lines 3–7 and loses to lines 0–1.
- R8: An `int_ack` pulse while a line wins sets that line's in-service bit. For a line 8–15 it also sets the in-service bit of lower-unit line 2. From the cycle after the pulse, `vec_out` holds 0x800 + line×16.
- R9: A line cannot be presented while an in-service bit of its own unit is set at its own position or at a higher-priority position.
- R10: A write to offset 0 of a unit with a value whose top five bits are 00100 (0x20 to 0x27) clears that unit's highest-priority set in-service bit. The low three bits have no effect. Other values written to offset 0 change nothing.
- R11: Reading offset 0 of a unit returns its in-service bits. Every read returns `reg_rdata` on the cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 16 | Interrupt lines 0–15 |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 lower unit, 1 upper unit, 2 trigger select |
| reg_off | input | 1 | Register offset within the selection |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered |
| int_ack | input | 1 | Host acknowledge pulse |
| host_irq | output | 1 | Registered request to the host |
| vec_out | output | 12 | Vector of the last acknowledged line |

## Verification
A corrupted in-service bit shows up at the ports in one of two ways:
- a line stays silent on `host_irq` even though its input toggled;
- a lower-priority line slips through while a higher-priority line is still in service.

Either symptom is visible within two cycles of the request settling, and the in-service readback at offset 0 exposes it after one read.

A stale edge latch produces an extra request with an unexpected vector after the next acknowledge. A wrong trigger-select or mask bit changes whether `host_irq` follows the input or holds, and a readback of the register exposes that directly.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_TRIG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // top five bits of a non-specific end-of-interrupt command
  localparam logic [4:0] EOI_TOP = 5'b00100;
endpackage

// File: rtl/irq_edge_level.sv
module irq_edge_level #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] line_in,
  input  logic [W-1:0] level_sel,
  input  logic [W-1:0] clr,
  output logic [W-1:0] req
);
  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] rise;

  assign rise = line_in & ~prev_q & ~level_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= line_in;
      latch_q <= (latch_q & ~clr) | rise;
    end
  end

  assign req = (line_in & level_sel) | (latch_q & ~level_sel);
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     req,
  input  logic             mask_we,
  input  logic [W-1:0]     mask_wdata,
  input  logic             eoi,
  input  logic             take,
  output logic             win_valid,
  output logic [IDX_W-1:0] win_idx,
  output logic [W-1:0]     imr,
  output logic [W-1:0]     isr
);
  logic [W-1:0] imr_q, isr_q;
  logic [W-1:0] blocked, eligible, top_isr, take_bit;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < W; i++) begin
      acc = acc | isr_q[i];
      blocked[i] = acc;
    end
  end

  assign eligible = req & ~imr_q & ~blocked;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    top_isr = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (isr_q[i]) top_isr = W'(1) << i;
    end
  end

  assign take_bit = (take && win_valid) ? (W'(1) << win_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q <= '1;
      isr_q <= '0;
    end else begin
      if (mask_we) imr_q <= mask_wdata;
      isr_q <= (isr_q & ~(eoi ? top_isr : '0)) | take_bit;
    end
  end

  assign imr = imr_q;
  assign isr = isr_q;
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int             UNIT_W       = 8,
  parameter int             CASCADE_LINE = 2,
  parameter int             VEC_W        = 12,
  parameter int             VEC_SHIFT    = 4,
  parameter logic [11:0]    VEC_BASE     = 12'h800,
  parameter logic [15:0]    FORCE_EDGE   = 16'h2107,
  localparam int            LINES        = 2 * UNIT_W,
  localparam int            IDX_W        = $clog2(UNIT_W),
  localparam int            LINE_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_in,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [1:0]        reg_sel,
  input  logic              reg_off,
  input  logic [UNIT_W-1:0] reg_wdata,
  output logic [UNIT_W-1:0] reg_rdata,
  input  logic              int_ack,
  output logic              host_irq,
  output logic [VEC_W-1:0]  vec_out
);
  logic [LINES-1:0]  trig_q;
  logic [LINES-1:0]  lvl_eff;
  logic [UNIT_W-1:0] u_line  [2];
  logic [UNIT_W-1:0] u_level [2];
  logic [UNIT_W-1:0] u_clr   [2];
  logic [UNIT_W-1:0] u_req   [2];
  logic [UNIT_W-1:0] u_imr   [2];
  logic [UNIT_W-1:0] u_isr   [2];
  logic [IDX_W-1:0]  u_idx   [2];
  logic              u_valid [2];
  logic              u_take  [2];
  logic              u_mwe   [2];
  logic              u_eoi   [2];

  logic              ack_go, to_high;
  logic [LINE_W-1:0] win_line;
  logic              is_cmd_eoi;
  logic [UNIT_W-1:0] m_req, imr_m, imr_s, isr_m;
  logic              m_valid, eoi_m, host_irq_q;
  logic [VEC_W-1:0]  vec_q;
  logic [UNIT_W-1:0] rdata_q;

  assign lvl_eff    = trig_q & ~FORCE_EDGE[LINES-1:0];
  assign is_cmd_eoi = (reg_wdata[UNIT_W-1:3] == (UNIT_W-3)'(EOI_TOP));
  assign ack_go     = int_ack && u_valid[0];
  assign to_high    = (u_idx[0] == IDX_W'(CASCADE_LINE));

  // line inputs and detect selects per unit; the cascade line follows the
  // upper unit's request directly
  always_comb begin
    u_line[1]  = irq_in[LINES-1:UNIT_W];
    u_level[1] = lvl_eff[LINES-1:UNIT_W];
    u_line[0]  = irq_in[UNIT_W-1:0];
    u_line[0][CASCADE_LINE]  = u_valid[1];
    u_level[0] = lvl_eff[UNIT_W-1:0];
    u_level[0][CASCADE_LINE] = 1'b1;
    u_take[0]  = ack_go;
    u_take[1]  = ack_go && to_high;
    u_clr[0]   = (ack_go && !to_high) ? (UNIT_W'(1) << u_idx[0]) : '0;
    u_clr[1]   = (ack_go && to_high) ? (UNIT_W'(1) << u_idx[1]) : '0;
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    assign u_mwe[u] = reg_we && (reg_sel == 2'(u)) && reg_off;
    assign u_eoi[u] = reg_we && (reg_sel == 2'(u)) && !reg_off && is_cmd_eoi;

    irq_edge_level #(.W(UNIT_W)) u_det (
      .clk       (clk),
      .rst       (rst),
      .line_in   (u_line[u]),
      .level_sel (u_level[u]),
      .clr       (u_clr[u]),
      .req       (u_req[u])
    );

    irq_prio_unit #(.W(UNIT_W)) u_prio (
      .clk        (clk),
      .rst        (rst),
      .req        (u_req[u]),
      .mask_we    (u_mwe[u]),
      .mask_wdata (reg_wdata),
      .eoi        (u_eoi[u]),
      .take       (u_take[u]),
      .win_valid  (u_valid[u]),
      .win_idx    (u_idx[u]),
      .imr        (u_imr[u]),
      .isr        (u_isr[u])
    );
  end

  assign m_req   = u_req[0];
  assign m_valid = u_valid[0];
  assign imr_m   = u_imr[0];
  assign imr_s   = u_imr[1];
  assign isr_m   = u_isr[0];
  assign eoi_m   = u_eoi[0];

  assign win_line = to_high ? {1'b1, u_idx[1]} : {1'b0, u_idx[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q     <= '0;
      host_irq_q <= 1'b0;
      vec_q      <= VEC_W'(VEC_BASE);
      rdata_q    <= '0;
    end else begin
      if (reg_we && reg_sel == SEL_TRIG) begin
        if (reg_off)
          trig_q[LINES-1:UNIT_W] <= reg_wdata & ~FORCE_EDGE[LINES-1:UNIT_W];
        else
          trig_q[UNIT_W-1:0] <= reg_wdata & ~FORCE_EDGE[UNIT_W-1:0];
      end
      host_irq_q <= m_valid;
      if (ack_go) vec_q <= VEC_W'(VEC_BASE) + (VEC_W'(win_line) << VEC_SHIFT);
      if (reg_re) begin
        unique case (reg_sel)
          SEL_LOW:  rdata_q <= reg_off ? u_imr[0] : u_isr[0];
          SEL_HIGH: rdata_q <= reg_off ? u_imr[1] : u_isr[1];
          SEL_TRIG: rdata_q <= reg_off ? trig_q[LINES-1:UNIT_W] : trig_q[UNIT_W-1:0];
          default:  rdata_q <= '0;
        endcase
      end
    end
  end

  assign host_irq  = host_irq_q;
  assign vec_out   = vec_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/cascade_irq_ctrl_chk.sv
module cascade_irq_ctrl_chk #(
  parameter int          UNIT_W     = 8,
  parameter int          LINES      = 16,
  parameter logic [15:0] FORCE_EDGE = 16'h2107
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [1:0]        reg_sel,
  input logic              int_ack,
  input logic              host_irq,
  input logic              m_valid,
  input logic              ack_go,
  input logic              eoi_m,
  input logic [UNIT_W-1:0] m_req,
  input logic [UNIT_W-1:0] imr_m,
  input logic [UNIT_W-1:0] imr_s,
  input logic [UNIT_W-1:0] isr_m,
  input logic [LINES-1:0]  trig_q
);
  // R1: reset leaves all lines masked and nothing in service
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (imr_m == '1 && imr_s == '1 && isr_m == '0 && !host_irq));

  // R3: fixed-edge lines never hold a level select after a write
  a_r3_forced_edge: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd2) |=> ((trig_q & FORCE_EDGE[LINES-1:0]) == '0));

  // R6: nothing unmasked on the lower unit means no host request next cycle
  a_r6_no_unmasked_req: assert property (@(posedge clk) disable iff (rst)
    ((m_req & ~imr_m) == '0) |=> !host_irq);

  // R8: an acknowledge with a winner leaves something in service
  a_r8_ack_sets_isr: assert property (@(posedge clk) disable iff (rst)
    (int_ack && m_valid) |=> (isr_m != '0));

  // R9: line 0 in service blocks every lower-unit winner
  a_r9_top_blocks_all: assert property (@(posedge clk) disable iff (rst)
    isr_m[0] |-> !m_valid);

  // R10: end-of-interrupt removes exactly one in-service bit
  a_r10_eoi_pops_one: assert property (@(posedge clk) disable iff (rst)
    (eoi_m && !ack_go && isr_m != '0) |=>
      ($countones(isr_m) == $countones($past(isr_m)) - 1));
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
  .UNIT_W(UNIT_W), .LINES(LINES), .FORCE_EDGE(FORCE_EDGE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .int_ack  (int_ack),
  .host_irq (host_irq),
  .m_valid  (m_valid),
  .ack_go   (ack_go),
  .eoi_m    (eoi_m),
  .m_req    (m_req),
  .imr_m    (imr_m),
  .imr_s    (imr_s),
  .isr_m    (isr_m),
  .trig_q   (trig_q)
);

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  localparam logic [15:0] FORCE = 16'h2107;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_in = '0;
  logic        reg_we = 1'b0, reg_re = 1'b0, reg_off = 1'b0, int_ack = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        host_irq;
  logic [11:0] vec_out;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_imr, s_imr, isr_m, isr_s;
  logic [15:0] trig, latch, cur_in;
  logic [11:0] last_vec;

  always #4 clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_we(reg_we), .reg_re(reg_re),
    .reg_sel(reg_sel), .reg_off(reg_off), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_ack(int_ack), .host_irq(host_irq),
    .vec_out(vec_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int unit_win(input logic [7:0] rq, input logic [7:0] msk,
                                  input logic [7:0] isr);
    logic acc = 1'b0;
    for (int i = 0; i < 8; i++) begin
      acc = acc | isr[i];
      if (!acc && rq[i] && !msk[i]) return i;
    end
    return -1;
  endfunction

  function automatic int model_line();
    logic [15:0] r;
    logic [7:0]  mr;
    int s, m;
    for (int i = 0; i < 16; i++)
      r[i] = (trig[i] & ~FORCE[i]) ? cur_in[i] : latch[i];
    s = unit_win(r[15:8], s_imr, isr_s);
    mr = r[7:0];
    mr[2] = (s >= 0);
    m = unit_win(mr, m_imr, isr_m);
    if (m < 0) return -1;
    return (m == 2) ? 8 + s : m;
  endfunction

  function automatic logic [7:0] pop_low(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return v & ~(8'd1 << i);
    return v;
  endfunction

  task automatic wr(input logic [1:0] sel, input logic off, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (sel == 2'd0 && off) m_imr = d;
    if (sel == 2'd1 && off) s_imr = d;
    if (sel == 2'd2) begin
      if (off) trig[15:8] = d & ~FORCE[15:8];
      else trig[7:0] = d & ~FORCE[7:0];
    end
    if (sel < 2'd2 && !off && d[7:3] == 5'b00100) begin
      if (sel == 2'd0) isr_m = pop_low(isr_m);
      else isr_s = pop_low(isr_s);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] sel, input logic off, output logic [7:0] d);
    @(negedge clk);
    reg_re = 1'b1; reg_sel = sel; reg_off = off;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [15:0] v);
    @(negedge clk);
    for (int i = 0; i < 16; i++)
      if (v[i] && !cur_in[i] && !(trig[i] & ~FORCE[i])) latch[i] = 1'b1;
    irq_in = v;
    cur_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_irq(input string req);
    chk(req, host_irq, model_line() >= 0);
  endtask

  task automatic check_isr(input string req);
    logic [7:0] d;
    rd(2'd0, 1'b0, d); chk(req, d, isr_m);
    rd(2'd1, 1'b0, d); chk(req, d, isr_s);
  endtask

  task automatic ack(input string req);
    int ln;
    ln = model_line();
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    if (ln >= 0) begin
      last_vec = 12'h800 + 12'(ln * 16);
      if (ln >= 8) begin
        isr_s[ln-8] = 1'b1;
        isr_m[2] = 1'b1;
      end else isr_m[ln] = 1'b1;
      latch[ln] = 1'b0;
    end
    chk(req, vec_out, last_vec);
    repeat (2) @(negedge clk);
  endtask

  task automatic eoi_line(input bit high);
    if (high) wr(2'd1, 1'b0, 8'h20 | 8'($urandom % 8));
    wr(2'd0, 1'b0, 8'h22);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20251));
    m_imr = '1; s_imr = '1; isr_m = '0; isr_s = '0;
    trig = '0; latch = '0; cur_in = '0; last_vec = 12'h800;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 host_irq", host_irq, 0);
    chk("R1 vec_out", vec_out, 12'h800);
    rd(2'd0, 1'b1, d); chk("R1 low mask", d, 8'hFF);
    rd(2'd1, 1'b1, d); chk("R1 high mask", d, 8'hFF);
    rd(2'd2, 1'b0, d); chk("R1 trig lo", d, 8'h00);
    check_isr("R1 isr");

    // R2 mask write and readback; R3 forced edge bits
    wr(2'd0, 1'b1, 8'h5A); rd(2'd0, 1'b1, d); chk("R2 low mask", d, 8'h5A);
    wr(2'd2, 1'b0, 8'hFF); rd(2'd2, 1'b0, d); chk("R3 trig lo", d, 8'hF8);
    wr(2'd2, 1'b1, 8'hFF); rd(2'd2, 1'b1, d); chk("R3 trig hi", d, 8'hDE);
    wr(2'd2, 1'b0, 8'h00); wr(2'd2, 1'b1, 8'h00);
    wr(2'd0, 1'b1, 8'h00); wr(2'd1, 1'b1, 8'h00);

    // R4 edge latch survives input fall; vector 0x830
    drive(16'h0008); drive(16'h0000);
    chk("R4 held", host_irq, 1);
    ack("R4 vector");
    chk("R4 vec", vec_out, 12'h830);
    // R9 line 5 blocked while 3 in service, line 1 passes
    drive(16'h0020);
    chk("R9 blocked", host_irq, 0);
    drive(16'h0022);
    chk("R9 higher", host_irq, 1);
    ack("R9 ack1");
    check_isr("R9 isr");
    // R10 wrong command ignored, then two pops
    wr(2'd0, 1'b0, 8'h40); check_isr("R10 ignored");
    eoi_line(0); eoi_line(0); check_isr("R10 pops");
    ack("R10 line5");
    chk("R10 vec", vec_out, 12'h850);
    eoi_line(0); drive(16'h0000);

    // R5 level drop before ack
    wr(2'd2, 1'b0, 8'h40);
    drive(16'h0040); chk("R5 level on", host_irq, 1);
    drive(16'h0000); chk("R5 level off", host_irq, 0);
    ack("R5 no change");
    check_isr("R5 isr");

    // R7 slave line beats line 3, loses to line 1
    drive(16'h0208); ack("R7 slave first");
    chk("R7 vec 9", vec_out, 12'h890);
    eoi_line(1); ack("R7 then 3"); eoi_line(0);
    drive(16'h0000); drive(16'h0402); ack("R7 line1");
    chk("R7 vec 1", vec_out, 12'h810);
    eoi_line(0); ack("R7 line10"); eoi_line(1);

    // R6 cascade gate and pin 2 ignored
    drive(16'h0000);
    wr(2'd0, 1'b1, 8'h04);
    drive(16'h8000); chk("R6 gated", host_irq, 0);
    drive(16'h0000); drive(16'h0004); chk("R6 pin2", host_irq, 0);
    wr(2'd0, 1'b1, 8'h00); check_irq("R6 released");
    ack("R6 line15"); eoi_line(1);
    check_isr("R11 readback");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int r = $urandom % 8;
      if (r == 0) wr(($urandom % 2) ? 2'd1 : 2'd0, 1'b1, 8'($urandom) & 8'hFB);
      else if (r == 1) begin
        logic ofs = 1'($urandom);
        wr(2'd2, ofs, 8'($urandom));
        rd(2'd2, ofs, d); chk("R3 rand trig", d, ofs ? trig[15:8] : trig[7:0]);
      end else drive(16'($urandom));
      check_irq("R7 rand irq");
      if (model_line() >= 0 && ($urandom % 2)) ack("R8 rand vec");
      if ((isr_m != 0) && ($urandom % 3 == 0)) begin
        eoi_line((isr_s != 0) && ($urandom % 2));
        check_isr("R10 rand isr");
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule